// File: doc/BRIEF.md
# Quadrature Bus Clock Generator

This block runs from a free-running oscillator at four times the bus rate and
derives the clocks of a multiplexed address/data bus from it. A quadrature
counter steps through four oscillator periods per bus cycle. Three clocks are
decoded from that counter:

- an internal phase clock;
- an external bus clock, which lags the phase clock by one oscillator period (a quarter of the bus cycle);
- an address strobe, used to latch the low-order address off the shared lines.

A one-period end-of-cycle marker flags the last quarter of every bus cycle. The
bus clock falls just after that quarter, so externally every bus cycle starts
and ends on a falling edge of the bus clock.

The block also sequences a low-power stop. A stop request takes effect only at
a bus-cycle boundary. From that boundary every output is parked low and the
counter is frozen. A wake event restarts the internal phase clock at once. The
bus clock and the address strobe stay parked until one complete internal bus
cycle has run, so internal logic sees clocks before the outside world does.

The sequencer has four named states:

- HOLD: entered by reset. Leaves to RUN on the first edge after reset is released.
- RUN: normal operation. Leaves to STOP when a stop request is present at the edge that closes a bus cycle.
- STOP: parked. Leaves to WAKE on a wake event.
- WAKE: the phase clock runs alone. Leaves to RUN at the edge that closes the first full cycle.

Top module: `qclk_gen`

## Requirements
- R1: While rst_n is low, ph_clk, bus_clk, addr_strobe and cyc_end are all low, and the counter is held at quarter 0.
- R2: On the first rising oscillator edge with rst_n high, a bus cycle begins in quarter 1 with all outputs low. ph_clk rises one edge later, bus_clk two edges later, and addr_strobe and cyc_end three edges later.
- R3: In RUN the counter steps 1, 2, 3, 0 once per oscillator period. ph_clk is high in quarters 2 and 3, which is two periods high out of every four.
- R4: bus_clk is high in quarters 3 and 0. It rises one period after ph_clk rises and falls one period after ph_clk falls.
- R5: addr_strobe is high for exactly quarter 0. bus_clk is high and ph_clk is low whenever it is high, so the strobe ends before the next rise of bus_clk.
- R6: cyc_end is high for exactly one period per bus cycle, in quarter 0, in both RUN and WAKE.
- R7: In STOP all four outputs are low and the counter stays at quarter 0 for as long as no wake event arrives.
- R8: stop_req is acted on only at the edge that leaves quarter 0 in RUN. A request raised in another quarter lets the current cycle complete first. The outputs go low on that boundary edge.
- R9: A wake event sampled in STOP starts quarter 1 on that edge, and ph_clk rises one edge later. For the four periods of that first cycle (quarters 1, 2, 3, 0), bus_clk and addr_strobe stay low and cyc_end pulses in quarter 0. Normal RUN output follows from the next quarter 1.
- R10: wake_evt has no effect in RUN, and stop_req has no effect during the WAKE cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, four periods per bus cycle |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| stop_req | input | 1 | Request to park the clocks at the next boundary |
| wake_evt | input | 1 | Event that ends the stop |
| ph_clk | output | 1 | Internal phase clock |
| bus_clk | output | 1 | External bus clock, one period behind ph_clk |
| addr_strobe | output | 1 | Address latch strobe, quarter 0 only |
| cyc_end | output | 1 | Marks the last quarter of each bus cycle |

## Verification
All outputs are registered, so each one changes on the same oscillator edge at which the sequencer enters the state and quarter that the output decodes. A stop or wake input sampled at an edge therefore shows at the outputs right after that edge. The driver applies inputs one period at a time and pushes the vector {ph_clk, bus_clk, addr_strobe, cyc_end} expected after the coming edge. The monitor pops and compares at the falling edge half a period later. The expected vectors come from the quarter tables above, including the three extra edges a stop request waits through when raised mid-cycle and the bus-less first cycle after a wake.

// File: rtl/qclk_pkg.sv
package qclk_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2,
        ST_WAKE = 2'd3
    } qclk_state_e;
endpackage

// File: rtl/qclk_seq.sv
module qclk_seq
    import qclk_pkg::*;
#(
    parameter int PHASES = 4,
    parameter int CW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop_req,
    input  logic          wake_evt,
    output qclk_state_e   state_q,
    output logic [CW-1:0] cnt_q,
    output qclk_state_e   state_nx,
    output logic [CW-1:0] cnt_nx
);
    localparam logic [CW-1:0] LAST  = CW'(PHASES - 1);
    localparam logic [CW-1:0] FIRST = CW'(1);

    logic [CW-1:0] cnt_step;

    always_comb begin
        cnt_step = (cnt_q == LAST) ? '0 : cnt_q + FIRST;
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                state_nx = ST_RUN;
                cnt_nx   = FIRST;
            end
            ST_RUN: begin
                if (cnt_q == '0 && stop_req) begin
                    state_nx = ST_STOP;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_step;
                end
            end
            ST_STOP: begin
                if (wake_evt) begin
                    state_nx = ST_WAKE;
                    cnt_nx   = FIRST;
                end
            end
            ST_WAKE: begin
                cnt_nx = cnt_step;
                if (cnt_q == '0) begin
                    state_nx = ST_RUN;
                end
            end
            default: begin
                state_nx = ST_HOLD;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end
endmodule

// File: rtl/qclk_decode.sv
module qclk_decode
    import qclk_pkg::*;
#(
    parameter int PHASES = 4,
    parameter int CW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  qclk_state_e   state_nx,
    input  logic [CW-1:0] cnt_nx,
    output logic          ph_clk,
    output logic          bus_clk,
    output logic          addr_strobe,
    output logic          cyc_end
);
    localparam logic [CW-1:0] HALF     = CW'(PHASES / 2);
    localparam logic [CW-1:0] BUS_FROM = CW'(PHASES / 2 + 1);

    logic ph_d, bus_d, as_d, end_d;
    logic ph_on, bus_on, q0;

    always_comb begin
        q0     = (cnt_nx == '0);
        ph_on  = (cnt_nx >= HALF);
        bus_on = q0 || (cnt_nx >= BUS_FROM);
        ph_d   = 1'b0;
        bus_d  = 1'b0;
        as_d   = 1'b0;
        end_d  = 1'b0;
        unique case (state_nx)
            ST_RUN: begin
                ph_d  = ph_on;
                bus_d = bus_on;
                as_d  = q0;
                end_d = q0;
            end
            ST_WAKE: begin
                ph_d  = ph_on;
                end_d = q0;
            end
            ST_HOLD, ST_STOP: begin
                ph_d = 1'b0;
            end
            default: begin
                ph_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_clk      <= 1'b0;
            bus_clk     <= 1'b0;
            addr_strobe <= 1'b0;
            cyc_end     <= 1'b0;
        end else begin
            ph_clk      <= ph_d;
            bus_clk     <= bus_d;
            addr_strobe <= as_d;
            cyc_end     <= end_d;
        end
    end
endmodule

// File: rtl/qclk_gen.sv
module qclk_gen
    import qclk_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake_evt,
    output logic ph_clk,
    output logic bus_clk,
    output logic addr_strobe,
    output logic cyc_end
);
    localparam int CW = $clog2(PHASES);

    qclk_state_e   state_q, state_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    qclk_seq #(.PHASES(PHASES), .CW(CW)) u_seq (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .wake_evt (wake_evt),
        .state_q  (state_q),
        .cnt_q    (cnt_q),
        .state_nx (state_nx),
        .cnt_nx   (cnt_nx)
    );

    qclk_decode #(.PHASES(PHASES), .CW(CW)) u_dec (
        .clk         (osc_clk),
        .rst_n       (rst_n),
        .state_nx    (state_nx),
        .cnt_nx      (cnt_nx),
        .ph_clk      (ph_clk),
        .bus_clk     (bus_clk),
        .addr_strobe (addr_strobe),
        .cyc_end     (cyc_end)
    );

    AST_STROBE_IN_BUS_HIGH: assert property (@(posedge osc_clk) disable iff (!rst_n)
        addr_strobe |-> (bus_clk && !ph_clk)); // R5
    AST_BUS_RISE_LAGS: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(bus_clk) |-> ($past(ph_clk) && ph_clk)); // R4
    AST_PH_TWO_WIDE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(ph_clk) |=> ph_clk); // R3
    AST_END_SINGLE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cyc_end |=> !cyc_end); // R6
    AST_STOP_QUIET: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (!ph_clk && !bus_clk && !addr_strobe && !cyc_end && cnt_q == '0)); // R7
    AST_STOP_AT_BOUNDARY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state_q == ST_STOP && $past(state_q) == ST_RUN) |-> ($past(cnt_q) == '0 && $past(stop_req))); // R8
    AST_WAKE_NO_BUS: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |-> (!bus_clk && !addr_strobe)); // R9
endmodule

// File: tb/qclk_gen_bench.sv
module qclk_gen_bench;
    logic osc_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic stop_req = 1'b0;
    logic wake_evt = 1'b0;
    logic ph_clk, bus_clk, addr_strobe, cyc_end;

    always #2.5 osc_clk = ~osc_clk;

    qclk_gen u_qclk_gen (
        .osc_clk     (osc_clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .wake_evt    (wake_evt),
        .ph_clk      (ph_clk),
        .bus_clk     (bus_clk),
        .addr_strobe (addr_strobe),
        .cyc_end     (cyc_end)
    );

    typedef struct {
        logic [3:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;

    // expected vector bits: {ph_clk, bus_clk, addr_strobe, cyc_end}
    localparam logic [3:0] V_Q1 = 4'b0000;
    localparam logic [3:0] V_Q2 = 4'b1000;
    localparam logic [3:0] V_Q3 = 4'b1100;
    localparam logic [3:0] V_Q0 = 4'b0111;
    localparam logic [3:0] V_OFF = 4'b0000;
    localparam logic [3:0] W_Q0 = 4'b0001;

    task automatic step(input logic r, input logic s, input logic w,
                        input logic [3:0] v, input string tag);
        exp_t e;
        @(negedge osc_clk);
        #1;
        rst_n    = r;
        stop_req = s;
        wake_evt = w;
        e.vec = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run_cycle(input logic w, input string tag);
        step(1'b1, 1'b0, w, V_Q1, tag);
        step(1'b1, 1'b0, w, V_Q2, tag);
        step(1'b1, 1'b0, w, V_Q3, tag);
        step(1'b1, 1'b0, w, V_Q0, tag);
    endtask

    always @(negedge osc_clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e   = exp_q.pop_front();
            act = {ph_clk, bus_clk, addr_strobe, cyc_end};
            n_vec++;
            if (act !== e.vec) begin
                n_bad++;
                $display("FAIL %s: outputs %b expected %b at %0t", e.tag, act, e.vec, $time);
            end
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, V_OFF, "R1 reset quiet");
        step(1'b0, 1'b1, 1'b1, V_OFF, "R1 reset ignores stop and wake");
        // first cycle after release
        step(1'b1, 1'b0, 1'b0, V_Q1, "R2 first quarter 1");
        step(1'b1, 1'b0, 1'b0, V_Q2, "R2 ph rises");
        step(1'b1, 1'b0, 1'b0, V_Q3, "R2 bus rises");
        step(1'b1, 1'b0, 1'b0, V_Q0, "R2 strobe and end");
        run_cycle(1'b0, "R3 R4 R5 R6 steady");
        run_cycle(1'b1, "R10 wake ignored in run");
        // stop raised mid cycle: waits for boundary
        step(1'b1, 1'b0, 1'b0, V_Q1, "R8 quarter 1");
        step(1'b1, 1'b1, 1'b0, V_Q2, "R8 stop in quarter 2 ignored");
        step(1'b1, 1'b1, 1'b0, V_Q3, "R8 stop in quarter 3 ignored");
        step(1'b1, 1'b1, 1'b0, V_Q0, "R8 cycle completes");
        step(1'b1, 1'b1, 1'b0, V_OFF, "R8 parked at boundary");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, V_OFF, "R7 stop frozen");
        // wake with stop held through the wake cycle
        step(1'b1, 1'b1, 1'b1, V_Q1, "R9 wake quarter 1");
        step(1'b1, 1'b1, 1'b0, V_Q2, "R9 ph resumes alone");
        step(1'b1, 1'b1, 1'b0, V_Q2, "R9 bus held low");
        step(1'b1, 1'b1, 1'b0, W_Q0, "R10 R9 end marker no strobe");
        step(1'b1, 1'b0, 1'b0, V_Q1, "R10 stop ignored in wake");
        step(1'b1, 1'b0, 1'b0, V_Q2, "R9 run restored");
        step(1'b1, 1'b0, 1'b0, V_Q3, "R9 bus back");
        step(1'b1, 1'b0, 1'b0, V_Q0, "R9 strobe back");
        // stop exactly at boundary, then wake at once
        step(1'b1, 1'b1, 1'b0, V_OFF, "R8 stop at boundary");
        step(1'b1, 1'b0, 1'b1, V_Q1, "R9 immediate wake");
        step(1'b1, 1'b0, 1'b0, V_Q2, "R9 ph");
        step(1'b1, 1'b0, 1'b0, V_Q2, "R9 no bus");
        step(1'b1, 1'b0, 1'b0, W_Q0, "R6 end in wake");
        run_cycle(1'b0, "R3 after wake");
        // reset mid cycle
        step(1'b1, 1'b0, 1'b0, V_Q1, "R3 quarter 1");
        step(1'b1, 1'b0, 1'b0, V_Q2, "R3 quarter 2");
        step(1'b0, 1'b0, 1'b0, V_OFF, "R1 reset mid cycle");
        step(1'b1, 1'b0, 1'b0, V_Q1, "R2 restart quarter 1");
        step(1'b1, 1'b0, 1'b0, V_Q2, "R2 restart ph");
        step(1'b1, 1'b0, 1'b0, V_Q3, "R2 restart bus");
        step(1'b1, 1'b0, 1'b0, V_Q0, "R2 restart strobe");
        @(negedge osc_clk);
        @(negedge osc_clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge osc_clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule